// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

This block keeps a running time base made of two counters: whole seconds and the milliseconds elapsed within the current second. A reference strobe arriving once per millisecond advances the millisecond count. When that count rolls over, the seconds count steps forward on the same clock edge. Both counters run without pause and serve as a persistent, monotonically rising time base.

Software reaches the counters through a small register port with a single-cycle access. A read of the millisecond register copies the live seconds value, as it stands in that cycle, into a separate snapshot register. Software reads milliseconds first and then the snapshot. It combines the two as seconds*1000 + milliseconds. The pair cannot tear even when the millisecond count rolls over between the two reads. There is only one snapshot register, so a second reader that reads milliseconds between those two accesses replaces the first reader's snapshot.

Top module: `rtc_snap_timer`

## Requirements
- R1: After reset, the seconds, milliseconds and snapshot values are all zero, and `bus_rdata` is zero whenever no read is presented.
- R2: The millisecond count never leaves the range 0 to 999.
- R3: A tick that arrives while milliseconds equal 999 (with no write to either counter) sets milliseconds to 0 and adds one to seconds on the same edge. A seconds value of 0xFFFFFFFF wraps to 0 without any other effect.
- R4: A tick while milliseconds are below 999 adds one to milliseconds and leaves seconds unchanged. Without a tick or a write, both counters hold their values.
- R5: A read (`bus_en`=1, `bus_we`=0) returns, in the same cycle: the live seconds for offset 0x08, the snapshot for offset 0x0c, and the milliseconds zero-extended to 32 bits for offset 0x10. Any other offset reads as zero.
- R6: A read of offset 0x10 loads the snapshot with the seconds value current in that cycle, before any increment that occurs on the same edge.
- R7: Only a read of offset 0x10 changes the snapshot. Writes to 0x0c and reads of 0x08 or 0x0c leave it unchanged.
- R8: A write (`bus_en`=1, `bus_we`=1) to offset 0x08 loads seconds from `bus_wdata`. This write takes precedence over an increment caused by a tick in the same cycle. The millisecond count still follows the tick.
- R9: A write to offset 0x10 loads milliseconds from `bus_wdata`, with any value above 999 stored as 999. This write overrides a tick in the same cycle, and seconds do not advance in that cycle.
- R10: A write to any offset other than 0x08 or 0x10 changes neither counter nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
Directed sequences drive the millisecond count to 998 and 999 with seconds near 0xFFFFFFFF. This separates a correct rollover of both counters from a carry that is missing or one cycle late, and it exercises the silent wrap of seconds. A millisecond read placed on the same cycle as a rollover tick shows whether the snapshot captures the seconds value from before or after the increment. Collisions of writes and ticks show which source wins. Random traffic mixes reads, writes, offsets that are not mapped, over-range millisecond writes and ticks at a high rate. A reference model in the bench checks every read and every idle cycle.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    // Register offsets; software depends on these positions
    localparam logic [7:0] OFS_SECONDS = 8'h08;
    localparam logic [7:0] OFS_SNAP    = 8'h0c;
    localparam logic [7:0] OFS_MILLI   = 8'h10;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SEC  = 2'd1,
        SEL_SNAP = 2'd2,
        SEL_MS   = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
    import rtc_snap_pkg::*;
(
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    output rd_sel_e    rd_sel,
    output logic       rd_ms,
    output logic       wr_sec,
    output logic       wr_ms
);

    logic hit_sec;
    logic hit_snap;
    logic hit_ms;

    always_comb begin
        hit_sec  = (bus_addr == OFS_SECONDS);
        hit_snap = (bus_addr == OFS_SNAP);
        hit_ms   = (bus_addr == OFS_MILLI);

        rd_sel = SEL_NONE;
        if (bus_en && !bus_we) begin
            if (hit_sec)       rd_sel = SEL_SEC;
            else if (hit_snap) rd_sel = SEL_SNAP;
            else if (hit_ms)   rd_sel = SEL_MS;
        end

        rd_ms  = bus_en && !bus_we && hit_ms;
        wr_sec = bus_en &&  bus_we && hit_sec;
        wr_ms  = bus_en &&  bus_we && hit_ms;
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int SEC_W      = 32,
    parameter int DATA_W     = 32,
    parameter int MS_PER_SEC = 1000,
    localparam int MS_W      = $clog2(MS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_sec,
    input  logic              wr_ms,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEC_W-1:0]  sec_q,
    output logic [MS_W-1:0]   ms_q
);

    localparam logic [MS_W-1:0]   MS_LAST  = MS_W'(MS_PER_SEC - 1);
    localparam logic [DATA_W-1:0] MS_LIMIT = DATA_W'(MS_PER_SEC - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MS_W-1:0]  ms;
    } time_t;

    time_t st_d, st_q;
    logic  roll;

    always_comb begin
        st_d = st_q;
        roll = tick && (st_q.ms == MS_LAST);

        if (wr_ms) begin
            st_d.ms = (wdata > MS_LIMIT) ? MS_LAST : wdata[MS_W-1:0];
        end else if (tick) begin
            st_d.ms = roll ? '0 : st_q.ms + 1'b1;
        end

        if (wr_sec) begin
            st_d.sec = wdata[SEC_W-1:0];
        end else if (roll && !wr_ms) begin
            st_d.sec = st_q.sec + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_q = st_q.sec;
    assign ms_q  = st_q.ms;

endmodule

// File: rtl/rtc_shadow_latch.sv
module rtc_shadow_latch #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEC_W-1:0] sec_in,
    output logic [SEC_W-1:0] snap_q
);

    logic [SEC_W-1:0] snap_d, snap_r;

    always_comb begin
        snap_d = capture ? sec_in : snap_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_r <= '0;
        else        snap_r <= snap_d;
    end

    assign snap_q = snap_r;

endmodule

// File: rtl/rtc_snap_timer.sv
module rtc_snap_timer
    import rtc_snap_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int DATA_W     = 32,
    parameter int MS_PER_SEC = 1000,
    localparam int MS_W      = $clog2(MS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    rd_sel_e          rd_sel;
    logic             rd_ms;
    logic             wr_sec;
    logic             wr_ms;
    logic [SEC_W-1:0] sec_cnt;
    logic [MS_W-1:0]  ms_cnt;
    logic [SEC_W-1:0] snap_val;

    rtc_reg_decode dec_i (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .rd_sel   (rd_sel),
        .rd_ms    (rd_ms),
        .wr_sec   (wr_sec),
        .wr_ms    (wr_ms)
    );

    rtc_time_core #(
        .SEC_W      (SEC_W),
        .DATA_W     (DATA_W),
        .MS_PER_SEC (MS_PER_SEC)
    ) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ms_tick),
        .wr_sec (wr_sec),
        .wr_ms  (wr_ms),
        .wdata  (bus_wdata),
        .sec_q  (sec_cnt),
        .ms_q   (ms_cnt)
    );

    rtc_shadow_latch #(
        .SEC_W (SEC_W)
    ) snap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_ms),
        .sec_in  (sec_cnt),
        .snap_q  (snap_val)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_SEC:  bus_rdata = DATA_W'(sec_cnt);
            SEL_SNAP: bus_rdata = DATA_W'(snap_val);
            SEL_MS:   bus_rdata = DATA_W'(ms_cnt);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_snap_timer_chk.sv
module rtc_snap_timer_chk
    import rtc_snap_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int DATA_W     = 32,
    parameter int MS_PER_SEC = 1000,
    localparam int MS_W      = $clog2(MS_PER_SEC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              bus_en,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SEC_W-1:0]  sec_q,
    input logic [MS_W-1:0]   ms_q,
    input logic [SEC_W-1:0]  snap_q
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic c_wr_sec, c_wr_ms, c_rd_ms, c_wr_any;
    assign c_wr_sec = bus_en && bus_we && (bus_addr == OFS_SECONDS);
    assign c_wr_ms  = bus_en && bus_we && (bus_addr == OFS_MILLI);
    assign c_rd_ms  = bus_en && !bus_we && (bus_addr == OFS_MILLI);
    assign c_wr_any = c_wr_sec || c_wr_ms;

    // R2
    ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MS_LAST);

    // R3
    rollover_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !c_wr_any && ms_q == MS_LAST)
        |=> (ms_q == '0 && sec_q == SEC_W'($past(sec_q) + 1'b1)));

    // R4
    ms_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !c_wr_any && ms_q != MS_LAST)
        |=> (ms_q == MS_W'($past(ms_q) + 1'b1) && $stable(sec_q)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !c_wr_any) |=> ($stable(ms_q) && $stable(sec_q)));

    // R6
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd_ms |=> (snap_q == $past(sec_q)));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rd_ms |=> $stable(snap_q));

    // R8
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_sec |=> (sec_q == $past(bus_wdata[SEC_W-1:0])));

endmodule

bind rtc_snap_timer rtc_snap_timer_chk #(
    .SEC_W      (SEC_W),
    .DATA_W     (DATA_W),
    .MS_PER_SEC (MS_PER_SEC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sec_q     (sec_cnt),
    .ms_q      (ms_cnt),
    .snap_q    (snap_val)
);

// File: tb/rtc_snap_timer_tb_top.sv
`timescale 1ns/1ps
module rtc_snap_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic [31:0] m_sec = '0;
    logic [31:0] m_ms  = '0;
    logic [31:0] m_snap = '0;

    always #2.5 clk = ~clk;

    rtc_snap_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h08:   return m_sec;
            8'h0c:   return m_snap;
            8'h10:   return m_ms;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        return (a == 8'h0c) ? "R6/R7 snapshot read" : "R5 read";
    endfunction

    function automatic logic [31:0] clamp_ms(input logic [31:0] v);
        return (v > 32'd999) ? 32'd999 : v;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, check read data, advance model at the edge
    task automatic step(input logic en, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input logic tk, input string tag);
        logic w_sec, w_ms, r_ms;
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; ms_tick = tk;
        #1;
        if (en && !we) check(bus_rdata, exp_read(a), {tag, " ", read_tag(a)});
        else           check(bus_rdata, 32'h0, {tag, " R1 idle rdata"});
        w_sec = en && we && (a == 8'h08);
        w_ms  = en && we && (a == 8'h10);
        r_ms  = en && !we && (a == 8'h10);
        @(posedge clk);
        if (r_ms) m_snap = m_sec;
        if (w_ms) begin
            m_ms = clamp_ms(wd);
        end else if (tk) begin
            if (m_ms == 32'd999) begin
                m_ms = 0;
                if (!w_sec) m_sec = m_sec + 1;
            end else begin
                m_ms = m_ms + 1;
            end
        end
        if (w_sec) m_sec = wd;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, 1'b0, tag);
    endtask

    task automatic tick(input string tag);
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h08, "R1"); rd(8'h10, "R1"); rd(8'h0c, "R1");
        step(1'b0, 1'b0, 8'h08, 32'h0, 1'b0, "R1");

        // R4 plain stepping and hold
        tick("R4"); tick("R4"); step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, "R4");
        rd(8'h10, "R4");

        // R3 rollover with seconds wrap
        wr(8'h08, 32'hFFFF_FFFF, "R8");
        wr(8'h10, 32'd998, "R9");
        tick("R3"); rd(8'h10, "R3 ms at 999"); tick("R3");
        rd(8'h10, "R3 ms wrapped"); rd(8'h08, "R3 sec wrapped");

        // R6 snapshot on the rollover edge takes the pre-increment seconds
        wr(8'h08, 32'd41, "R8");
        wr(8'h10, 32'd999, "R9");
        step(1'b1, 1'b0, 8'h10, 32'h0, 1'b1, "R6 read ms with tick");
        rd(8'h0c, "R6 snapshot 41");
        rd(8'h08, "R3 sec 42");

        // R9 clamp and write-over-tick
        wr(8'h10, 32'd5000, "R9 clamp");
        rd(8'h10, "R9 clamp");
        step(1'b1, 1'b1, 8'h10, 32'd999, 1'b1, "R9 write ms with tick");
        rd(8'h08, "R9 no carry"); rd(8'h10, "R9 ms 999");

        // R8 seconds write during rollover tick
        step(1'b1, 1'b1, 8'h08, 32'd700, 1'b1, "R8 write sec with tick");
        rd(8'h08, "R8 sec 700"); rd(8'h10, "R8 ms wrapped");

        // R7 and R10 writes that must not land
        wr(8'h0c, 32'hDEAD_BEEF, "R7");
        rd(8'h0c, "R7 snapshot unchanged");
        wr(8'h14, 32'd123, "R10"); wr(8'h04, 32'd9, "R10");
        rd(8'h08, "R10"); rd(8'h10, "R10"); rd(8'h0c, "R10");
        rd(8'h20, "R5 unmapped");

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        en, we, tk;
            case ($urandom % 6)
                0: a = 8'h08; 1: a = 8'h0c; 2: a = 8'h10;
                3: a = 8'h10; 4: a = 8'h04; default: a = 8'h14;
            endcase
            en = ($urandom % 4) != 0;
            we = ($urandom % 5) == 0;
            tk = ($urandom % 2) == 0;
            if (a == 8'h10) d = $urandom % 1100;
            else d = (($urandom % 3) == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom;
            step(en, we, a, d, tk, "RND");
        end
        rd(8'h10, "R2 final"); rd(8'h0c, "R6 final"); rd(8'h08, "R3 final");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule